// File: doc/BRIEF.md
# 64-bit Integer Decode and Control-Flow Execute Stage

This block accepts one 32-bit instruction of a 64-bit base integer core together with its program counter, the already-read first source register value and a pre-extracted immediate field. It classifies the instruction by matching a condensed 15-bit key against patterns in which some fields are don't-care. For the upper-immediate and jump instructions it computes the value to write back and the next program counter. For every other legal instruction it reports the class and sequential next PC, leaving the arithmetic, memory and branch-condition work to neighbouring stages.

A small control sequencer steps each accepted instruction through three states: operand capture and decode, execute, and writeback. The writeback state is either a register write state or a no-write state, chosen from the class. The outputs are registered and a one-cycle `done_o` pulse marks them valid. A new instruction is taken only when the block is idle.

Top module: `rvfx_core`

## Requirements
- R1: The match key is {instr[31:25], instr[14:12], instr[6:2]}. For the classes LUI (opcode[6:2]=01101), AUIPC (00101) and JAL (11011), and for the immediate ALU operations with funct3 000, 010, 011, 100, 110 or 111 on opcode 00100, funct7 and funct3 are not part of the match. `class_o` codes: 0 illegal, 1 LUI, 2 AUIPC, 3 JAL, 4 JALR, 5 branch, 6 load, 7 store, 8 ALU-immediate, 9 ALU-register, 10 ALU-immediate-word (opcode 00110), 11 ALU-register-word (opcode 01110).
- R2: For opcode 01100 and 01110, funct7 must be 0000000. The one exception is 0100000, which is allowed with funct3 000 (subtract) and 101 (arithmetic right shift). Any other funct7 is illegal.
- R3: The shift-immediate encodings (funct3 001 and 101 on opcodes 00100 and 00110) match only with funct7 0000000. Funct3 101 also matches with 0100000. Any other funct7 is illegal.
- R4: Opcode 11001 is JALR only with funct3 000. Opcode 11000 is a branch for funct3 000, 001, 100, 101, 110 and 111. Loads (opcode 00000) accept funct3 000 to 110. Stores (opcode 01000) accept funct3 000 to 011. All other funct3 values are illegal.
- R5: LUI writes imm_i[19:0] shifted left by 12 and sign-extended from bit 31. The next PC is pc+4.
- R6: AUIPC writes pc plus the R5 value. The next PC is pc+4.
- R7: JAL writes pc+4. The next PC is pc plus imm_i[20:0] sign-extended from bit 20.
- R8: JALR writes pc+4. The next PC is rs1 plus imm_i[11:0] sign-extended from bit 11, with bit 0 cleared.
- R9: An instruction is accepted when start_i is high while busy_o is low. done_o pulses for exactly one cycle, on the third rising edge after the accepting edge. busy_o stays high from acceptance through the done cycle. A start_i that arrives while the block is busy is ignored.
- R10: rd_we_o is high in the done cycle for classes 1–4 and 8–11 when rd (instr[11:7]) is non-zero. It stays low for rd=0 and for branches, loads and stores. For classes other than 1–4, wb_data_o is 0 and the next PC is pc+4. rs1_idx_o and rs2_idx_o show instr[19:15] and instr[24:20] of the accepted instruction.
- R11: An unmatched key, or instr[1:0] other than 11, gives class 0 and illegal_o=1 in the done cycle. In that case there is no register write, wb_data_o is 0 and the next PC equals pc.
- R12: During reset, busy_o, done_o, rd_we_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Offer an instruction |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 64 | Program counter of the instruction |
| rs1_i | input | 64 | First source register value |
| imm_i | input | 21 | Pre-extracted immediate field |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | Results valid, one cycle |
| class_o | output | 4 | Class code |
| illegal_o | output | 1 | Illegal instruction |
| rd_we_o | output | 1 | Register write enable |
| rd_o | output | 5 | Destination register index |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| wb_data_o | output | 64 | Writeback value |
| next_pc_o | output | 64 | Next program counter |

## Verification
If the class register decodes wrongly, the error shows at the ports in the very next done pulse. It appears as a wrong class code, a missing or spurious register write, or a wrong next PC, all within three cycles of the start. If the sequencer stalls or skips a state, done_o moves away from its fixed three-cycle slot, or it appears with no instruction accepted. The bench checks each done against the expected cycle. It also pairs each done with the offered instruction, so an extra or missing pulse is reported at the next completion.

// File: rtl/rvfx_pkg.sv
package rvfx_pkg;

  typedef enum logic [3:0] {
    CL_ILLEGAL = 4'd0,
    CL_LUI     = 4'd1,
    CL_AUIPC   = 4'd2,
    CL_JAL     = 4'd3,
    CL_JALR    = 4'd4,
    CL_BRANCH  = 4'd5,
    CL_LOAD    = 4'd6,
    CL_STORE   = 4'd7,
    CL_ALU_I   = 4'd8,
    CL_ALU_R   = 4'd9,
    CL_ALU_IW  = 4'd10,
    CL_ALU_RW  = 4'd11
  } cls_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEC   = 3'd1,
    ST_EXE   = 3'd2,
    ST_WBREG = 3'd3,
    ST_WBNO  = 3'd4
  } st_e;

  localparam int KEY_W = 15;

  // classes that end in a register write
  function automatic logic cls_writes_reg(cls_e c);
    case (c)
      CL_LUI, CL_AUIPC, CL_JAL, CL_JALR,
      CL_ALU_I, CL_ALU_R, CL_ALU_IW, CL_ALU_RW: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rvfx_rst_sync.sv
module rvfx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rvfx_keyclass.sv
module rvfx_keyclass
  import rvfx_pkg::*;
(
  input  logic [KEY_W-1:0] key_i,
  input  logic [1:0]       size_i,
  output cls_e             cls_o
);
  cls_e match_cls;

  // key layout: [14:8] funct7, [7:5] funct3, [4:0] opcode[6:2]
  always_comb begin
    casez (key_i)
      15'b???????_???_01101: match_cls = CL_LUI;
      15'b???????_???_00101: match_cls = CL_AUIPC;
      15'b???????_???_11011: match_cls = CL_JAL;
      15'b???????_000_11001: match_cls = CL_JALR;
      15'b???????_00?_11000,
      15'b???????_1??_11000: match_cls = CL_BRANCH;
      15'b???????_0??_00000,
      15'b???????_10?_00000,
      15'b???????_110_00000: match_cls = CL_LOAD;
      15'b???????_0??_01000: match_cls = CL_STORE;
      15'b???????_000_00100,
      15'b???????_01?_00100,
      15'b???????_1?0_00100,
      15'b???????_111_00100,
      15'b0000000_001_00100,
      15'b0000000_101_00100,
      15'b0100000_101_00100: match_cls = CL_ALU_I;
      15'b0000000_???_01100,
      15'b0100000_000_01100,
      15'b0100000_101_01100: match_cls = CL_ALU_R;
      15'b???????_000_00110,
      15'b0000000_001_00110,
      15'b0000000_101_00110,
      15'b0100000_101_00110: match_cls = CL_ALU_IW;
      15'b0000000_000_01110,
      15'b0000000_001_01110,
      15'b0000000_101_01110,
      15'b0100000_000_01110,
      15'b0100000_101_01110: match_cls = CL_ALU_RW;
      default:               match_cls = CL_ILLEGAL;
    endcase
  end

  assign cls_o = (size_i == 2'b11) ? match_cls : CL_ILLEGAL;
endmodule

// File: rtl/rvfx_flow_unit.sv
module rvfx_flow_unit
  import rvfx_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 21
) (
  input  cls_e             cls_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  res_o,
  output logic [XLEN-1:0]  npc_o
);
  localparam int U_W = 32;
  localparam int J_W = 21;
  localparam int I_W = 12;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [U_W-1:0]  u_raw;
  logic [XLEN-1:0] u_val, j_off, i_off, seq_pc, jalr_sum;

  assign u_raw    = {imm_i[19:0], 12'h000};
  assign u_val    = {{(XLEN-U_W){u_raw[U_W-1]}}, u_raw};
  assign j_off    = {{(XLEN-J_W){imm_i[J_W-1]}}, imm_i[J_W-1:0]};
  assign i_off    = {{(XLEN-I_W){imm_i[I_W-1]}}, imm_i[I_W-1:0]};
  assign seq_pc   = pc_i + STEP;
  assign jalr_sum = rs1_i + i_off;

  always_comb begin
    res_o = '0;
    npc_o = seq_pc;
    case (cls_i)
      CL_LUI:   res_o = u_val;
      CL_AUIPC: res_o = pc_i + u_val;
      CL_JAL: begin
        res_o = seq_pc;
        npc_o = pc_i + j_off;
      end
      CL_JALR: begin
        res_o = seq_pc;
        npc_o = {jalr_sum[XLEN-1:1], 1'b0};
      end
      CL_ILLEGAL: npc_o = pc_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/rvfx_ctrl.sv
module rvfx_ctrl
  import rvfx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  cls_e cls_i,
  output logic cap_op_o,
  output logic cap_cls_o,
  output logic cap_res_o,
  output logic busy_o,
  output logic done_o,
  output logic wb_reg_o
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_DEC;
      ST_DEC:   st_d = ST_EXE;
      ST_EXE:   st_d = cls_writes_reg(cls_i) ? ST_WBREG : ST_WBNO;
      ST_WBREG,
      ST_WBNO:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign cap_op_o  = (st_q == ST_IDLE) && start_i;
  assign cap_cls_o = (st_q == ST_DEC);
  assign cap_res_o = (st_q == ST_EXE);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_WBREG) || (st_q == ST_WBNO);
  assign wb_reg_o  = (st_q == ST_WBREG);
endmodule

// File: rtl/rvfx_core.sv
module rvfx_core
  import rvfx_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 21,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [3:0]       class_o,
  output logic             illegal_o,
  output logic             rd_we_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rs1_idx_o,
  output logic [REG_W-1:0] rs2_idx_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic [XLEN-1:0]  next_pc_o
);
  logic rst_sync_n;
  logic cap_op, cap_cls, cap_res, wb_reg;

  logic [31:0]      instr_q;
  logic [XLEN-1:0]  pc_q, rs1_q, res_q, npc_q, res_d, npc_d;
  logic [IMM_W-1:0] imm_q;
  logic [KEY_W-1:0] key;
  cls_e             cls_d, cls_q;

  rvfx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_sync_n)
  );

  rvfx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .cls_i(cls_q),
    .cap_op_o(cap_op), .cap_cls_o(cap_cls), .cap_res_o(cap_res),
    .busy_o(busy_o), .done_o(done_o), .wb_reg_o(wb_reg)
  );

  // operand capture, datapath registers without reset
  always_ff @(posedge clk) begin
    if (cap_op) begin
      instr_q <= instr_i;
      pc_q    <= pc_i;
      rs1_q   <= rs1_i;
      imm_q   <= imm_i;
    end
  end

  assign key = {instr_q[31:25], instr_q[14:12], instr_q[6:2]};

  rvfx_keyclass u_key (
    .key_i(key), .size_i(instr_q[1:0]), .cls_o(cls_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cls_q <= CL_ILLEGAL;
    else if (cap_cls) cls_q <= cls_d;
  end

  rvfx_flow_unit #(.XLEN(XLEN), .IMM_W(IMM_W)) u_flow (
    .cls_i(cls_q), .pc_i(pc_q), .rs1_i(rs1_q), .imm_i(imm_q),
    .res_o(res_d), .npc_o(npc_d)
  );

  always_ff @(posedge clk) begin
    if (cap_res) begin
      res_q <= res_d;
      npc_q <= npc_d;
    end
  end

  assign rd_o      = instr_q[11:7];
  assign rs1_idx_o = instr_q[19:15];
  assign rs2_idx_o = instr_q[24:20];
  assign class_o   = cls_q;
  assign illegal_o = done_o && (cls_q == CL_ILLEGAL);
  assign rd_we_o   = wb_reg && (rd_o != '0);
  assign wb_data_o = res_q;
  assign next_pc_o = npc_q;
endmodule

// File: rtl/rvfx_chk.sv
module rvfx_chk
  import rvfx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [3:0]      class_o,
  input logic            illegal_o,
  input logic            rd_we_o,
  input logic [XLEN-1:0] next_pc_o
);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |-> ##3 done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  // R11
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_o) |-> !rd_we_o);
  // R10
  write_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> done_o);
  // R8
  jalr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && class_o == CL_JALR) |-> !next_pc_o[0]);
endmodule

bind rvfx_core rvfx_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .class_o(class_o), .illegal_o(illegal_o),
  .rd_we_o(rd_we_o), .next_pc_o(next_pc_o)
);

// File: tb/tb_rvfx_core.sv
module tb_rvfx_core;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, start_i;
  logic [31:0]     instr_i;
  logic [63:0]     pc_i, rs1_i;
  logic [20:0]     imm_i;
  logic            busy_o, done_o, illegal_o, rd_we_o;
  logic [3:0]      class_o;
  logic [4:0]      rd_o, rs1_idx_o, rs2_idx_o;
  logic [63:0]     wb_data_o, next_pc_o;

  rvfx_core dut (.*);

  typedef struct {
    logic [3:0]  cls;
    logic        ill;
    logic        we;
    logic [4:0]  rd, r1, r2;
    logic [63:0] data, npc;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [63:0] v, input int msb);
    logic [63:0] hi;
    hi = ~64'h0 << msb;
    return v[msb] ? (v | hi) : (v & ~hi);
  endfunction

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] r2,
                                     input logic [4:0] r1, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [4:0] op);
    return {f7, r2, r1, f3, rd, op, 2'b11};
  endfunction

  // monitor: pop and compare on every done pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done_o === 1'b1) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 64'(cyc), 64'(0));
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.due, "R9", {e.tag, " done cycle"}, 64'(cyc), 64'(e.due));
        chk(class_o == e.cls, "R1", {e.tag, " class"}, 64'(class_o), 64'(e.cls));
        chk(illegal_o == e.ill, "R11", {e.tag, " illegal"}, 64'(illegal_o), 64'(e.ill));
        chk(rd_we_o == e.we, "R10", {e.tag, " write enable"}, 64'(rd_we_o), 64'(e.we));
        chk(rd_o == e.rd && rs1_idx_o == e.r1 && rs2_idx_o == e.r2, "R10",
            {e.tag, " register indices"}, 64'({rd_o, rs1_idx_o, rs2_idx_o}),
            64'({e.rd, e.r1, e.r2}));
        chk(wb_data_o == e.data, "R5", {e.tag, " writeback data"}, wb_data_o, e.data);
        chk(next_pc_o == e.npc, "R7", {e.tag, " next pc"}, next_pc_o, e.npc);
      end
    end
  end

  // driver: computes the expected item from the requirements and pushes it
  task automatic issue(input logic [31:0] ins, input logic [63:0] pc,
                       input logic [63:0] rs1, input logic [20:0] imm,
                       input logic [3:0] cls, input string tag,
                       input bit poke_busy);
    exp_t e;
    logic [63:0] u;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    u      = sx({32'h0, imm[19:0], 12'h000}, 31);
    e.cls  = cls;
    e.ill  = (cls == 4'd0);
    e.rd   = ins[11:7];
    e.r1   = ins[19:15];
    e.r2   = ins[24:20];
    e.data = 64'h0;
    e.npc  = pc + 64'd4;
    e.tag  = tag;
    e.due  = cyc + 3;
    case (cls)
      4'd0: e.npc = pc;
      4'd1: e.data = u;
      4'd2: e.data = pc + u;
      4'd3: begin e.data = pc + 64'd4; e.npc = pc + sx(64'(imm), 20); end
      4'd4: begin e.data = pc + 64'd4; e.npc = (rs1 + sx(64'(imm[11:0]), 11)) & ~64'h1; end
      default: ;
    endcase
    e.we = ((cls >= 4'd1 && cls <= 4'd4) || (cls >= 4'd8 && cls <= 4'd11)) && (e.rd != 5'd0);
    q.push_back(e);
    instr_i = ins; pc_i = pc; rs1_i = rs1; imm_i = imm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy) begin
      // R9: a second start while busy must be ignored
      instr_i = mk(7'h0, 5'd1, 5'd2, 3'b000, 5'd9, 5'b01100);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 64'(cyc), 64'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; instr_i = '0; pc_i = '0; rs1_i = '0; imm_i = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(busy_o == 1'b0 && done_o == 1'b0, "R12", "busy/done in reset",
        64'({busy_o, done_o}), 64'(0));
    chk(rd_we_o == 1'b0 && illegal_o == 1'b0, "R12", "we/illegal in reset",
        64'({rd_we_o, illegal_o}), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 LUI, random funct fields
    issue(mk(7'h55, 5'd3, 5'd7, 3'b101, 5'd5, 5'b01101), 64'h1000, 64'h0, 21'h12345, 4'd1, "R5 lui pos", 1'b0);
    issue(mk(7'h00, 5'd0, 5'd0, 3'b000, 5'd6, 5'b01101), 64'h1000, 64'h0, 21'h80000, 4'd1, "R5 lui neg", 1'b0);
    // R6 AUIPC
    issue(mk(7'h7f, 5'd31, 5'd31, 3'b111, 5'd8, 5'b00101), 64'h1000, 64'h0, 21'h0FFFF, 4'd2, "R6 auipc", 1'b0);
    issue(mk(7'h01, 5'd0, 5'd0, 3'b010, 5'd8, 5'b00101), 64'h2000, 64'h0, 21'h000FF, 4'd2, "R6 auipc up", 1'b0);
    // R7 JAL forward/backward, rd=0
    issue(mk(7'h12, 5'd4, 5'd4, 3'b011, 5'd1, 5'b11011), 64'h2000, 64'h0, 21'h1FFFFC, 4'd3, "R7 jal back", 1'b0);
    issue(mk(7'h00, 5'd0, 5'd0, 3'b000, 5'd0, 5'b11011), 64'h4000, 64'h0, 21'h00800, 4'd3, "R7 jal rd0", 1'b0);
    // R8 JALR with odd sum and negative offset; R4 wrong funct3
    issue(mk(7'h00, 5'd0, 5'd10, 3'b000, 5'd1, 5'b11001), 64'h5000, 64'h3001, 21'h004, 4'd4, "R8 jalr odd", 1'b0);
    issue(mk(7'h00, 5'd0, 5'd10, 3'b000, 5'd2, 5'b11001), 64'h5000, 64'h3000, 21'h0FFF, 4'd4, "R8 jalr neg", 1'b0);
    issue(mk(7'h00, 5'd0, 5'd10, 3'b010, 5'd2, 5'b11001), 64'h5100, 64'h3000, 21'h004, 4'd0, "R4 jalr f3", 1'b0);
    // R2 register ops
    issue(mk(7'h00, 5'd2, 5'd3, 3'b000, 5'd4, 5'b01100), 64'h6000, 64'h0, 21'h0, 4'd9, "R2 add", 1'b0);
    issue(mk(7'h20, 5'd2, 5'd3, 3'b000, 5'd4, 5'b01100), 64'h6004, 64'h0, 21'h0, 4'd9, "R2 sub", 1'b0);
    issue(mk(7'h20, 5'd2, 5'd3, 3'b101, 5'd4, 5'b01100), 64'h6008, 64'h0, 21'h0, 4'd9, "R2 sra", 1'b0);
    issue(mk(7'h01, 5'd2, 5'd3, 3'b000, 5'd4, 5'b01100), 64'h600c, 64'h0, 21'h0, 4'd0, "R2 add f7 bad", 1'b0);
    issue(mk(7'h20, 5'd2, 5'd3, 3'b100, 5'd4, 5'b01100), 64'h6010, 64'h0, 21'h0, 4'd0, "R2 xor f7 bad", 1'b0);
    issue(mk(7'h20, 5'd2, 5'd3, 3'b000, 5'd4, 5'b01110), 64'h6014, 64'h0, 21'h0, 4'd11, "R2 subw", 1'b0);
    issue(mk(7'h20, 5'd2, 5'd3, 3'b001, 5'd4, 5'b01110), 64'h6018, 64'h0, 21'h0, 4'd0, "R2 sllw f7 bad", 1'b0);
    // R1 / R3 immediate ops
    issue(mk(7'h7f, 5'd9, 5'd3, 3'b000, 5'd4, 5'b00100), 64'h7000, 64'h0, 21'h0, 4'd8, "R1 addi f7 any", 1'b0);
    issue(mk(7'h6a, 5'd9, 5'd3, 3'b011, 5'd0, 5'b00100), 64'h7004, 64'h0, 21'h0, 4'd8, "R1 sltiu rd0", 1'b0);
    issue(mk(7'h20, 5'd9, 5'd3, 3'b101, 5'd4, 5'b00100), 64'h7008, 64'h0, 21'h0, 4'd8, "R3 srai", 1'b0);
    issue(mk(7'h30, 5'd9, 5'd3, 3'b101, 5'd4, 5'b00100), 64'h700c, 64'h0, 21'h0, 4'd0, "R3 srai f7 bad", 1'b0);
    issue(mk(7'h01, 5'd9, 5'd3, 3'b001, 5'd4, 5'b00100), 64'h7010, 64'h0, 21'h0, 4'd0, "R3 slli f7 bad", 1'b0);
    issue(mk(7'h20, 5'd9, 5'd3, 3'b101, 5'd4, 5'b00110), 64'h7014, 64'h0, 21'h0, 4'd10, "R3 sraiw", 1'b0);
    issue(mk(7'h55, 5'd9, 5'd3, 3'b000, 5'd4, 5'b00110), 64'h7018, 64'h0, 21'h0, 4'd10, "R1 addiw f7 any", 1'b0);
    // R4 branches, loads, stores
    issue(mk(7'h00, 5'd1, 5'd2, 3'b000, 5'd3, 5'b11000), 64'h8000, 64'h0, 21'h0, 4'd5, "R4 beq", 1'b0);
    issue(mk(7'h00, 5'd1, 5'd2, 3'b110, 5'd3, 5'b11000), 64'h8004, 64'h0, 21'h0, 4'd5, "R4 bltu", 1'b0);
    issue(mk(7'h00, 5'd1, 5'd2, 3'b010, 5'd3, 5'b11000), 64'h8008, 64'h0, 21'h0, 4'd0, "R4 branch f3 bad", 1'b0);
    issue(mk(7'h00, 5'd1, 5'd2, 3'b011, 5'd3, 5'b00000), 64'h800c, 64'h0, 21'h0, 4'd6, "R4 ld", 1'b0);
    issue(mk(7'h00, 5'd1, 5'd2, 3'b111, 5'd3, 5'b00000), 64'h8010, 64'h0, 21'h0, 4'd0, "R4 load f3 bad", 1'b0);
    issue(mk(7'h00, 5'd1, 5'd2, 3'b011, 5'd3, 5'b01000), 64'h8014, 64'h0, 21'h0, 4'd7, "R4 sd", 1'b0);
    issue(mk(7'h00, 5'd1, 5'd2, 3'b100, 5'd3, 5'b01000), 64'h8018, 64'h0, 21'h0, 4'd0, "R4 store f3 bad", 1'b0);
    // R11 unknown opcode and wrong size bits
    issue(mk(7'h00, 5'd1, 5'd2, 3'b000, 5'd3, 5'b11111), 64'h9000, 64'h0, 21'h0, 4'd0, "R11 opcode", 1'b0);
    issue(mk(7'h00, 5'd1, 5'd2, 3'b000, 5'd3, 5'b00100) & 32'hFFFF_FFFD, 64'h9004, 64'h0, 21'h0, 4'd0, "R11 size bits", 1'b0);
    // R9 start while busy is ignored
    issue(mk(7'h00, 5'd0, 5'd0, 3'b000, 5'd7, 5'b01101), 64'hA000, 64'h0, 21'h00001, 4'd1, "R9 busy poke", 1'b1);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9", "items left undelivered", 64'(q.size()), 64'(0));
    chk(busy_o == 1'b0, "R9", "idle after last", 64'(busy_o), 64'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule